// File: doc/BRIEF.md
# Hash Engine Job Register Front-End

This block sits between a 32-bit register bus and a hash compression back-end. Software loads the source, digest-state and key buffer addresses and the data length into plain read/write registers. It then writes a command word. The command word carries an algorithm code, an accumulate flag that keeps running state across jobs, and a big-endian flag. If the algorithm code is valid and no job is running, the block sends a one-cycle start pulse to the back-end and holds the configuration steady on its outputs until the back-end answers with a done pulse.

A status word reports three things: whether a job is in flight, a sticky completion flag that also drives the interrupt line, and a sticky error flag for commands the block refused. Both sticky flags are cleared by writing one to their bit. A command written while a job is in flight is dropped. A command with an unknown algorithm code completes at once with the error flag set, and the back-end never sees it.

Top module: `hacc_csr`

## Requirements
- R1: After reset every register (status 0x1C, source 0x20, digest 0x24, key 0x28, length 0x2C, command 0x30) reads zero, `be_start` is low and `irq` is low.
- R2: The four configuration registers at 0x20, 0x24, 0x28 and 0x2C read back the last value written to them, and drive `be_src`, `be_digest`, `be_key` and `be_len` respectively.
- R3: A command write while idle with a valid algorithm code makes `be_start` high for exactly the one cycle after the write. In that same cycle status bit 0 (busy) is set. The code is built from command bits {10,6,5,4} and maps onto `be_algo` as follows: 4'b0010 gives 0, 4'b0101 gives 1, 4'b1110 gives 2 and 4'b0110 gives 3. `be_accum` follows command bit 8 and `be_bigend` follows command bit 3.
- R4: When `be_done` is sampled while busy, the same clock edge clears busy and sets status bit 9 (done), and `irq` follows bit 9.
- R5: A command write while busy is ignored: there is no start pulse, the command register readback is unchanged, and the back-end configuration outputs are unchanged.
- R6: Writing status with bit 9 set clears the done flag, and writing status with bit 9 clear leaves it alone. If a completion and a clear arrive in the same cycle, the flag ends up set.
- R7: A command write while idle with any other algorithm code sets done (bit 9) and error (bit 23) on the next edge. It produces no start pulse and leaves busy clear, and the command register still reads back the written word.
- R8: Writing status with bit 23 set clears the error flag without touching the done flag.
- R9: A `be_done` pulse while idle changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level copy of the done flag |
| be_start | output | 1 | One-cycle job launch pulse to the back-end |
| be_src | output | DW | Source buffer address |
| be_digest | output | DW | Digest/state buffer address |
| be_key | output | DW | Key buffer address |
| be_len | output | DW | Data length in bytes |
| be_algo | output | 2 | Algorithm index (0..3) from the accepted command |
| be_accum | output | 1 | Accumulate mode from the accepted command |
| be_bigend | output | 1 | Big-endian handling from the accepted command |
| be_done | input | 1 | One-cycle job completion pulse from the back-end |

## Verification
Every register effect lands on the edge that samples the write. A bench write task drives at a falling edge and returns at the next falling edge, so one nanosecond later the readback, the start pulse and the busy or error bits can be checked with zero further cycles of wait. The start pulse is checked again one cycle later to confirm it has dropped. Completion is due one edge after `be_done` is seen high: the bench polls for the pulse at falling edges, advances exactly one cycle, and then expects busy clear and done set. For the ignored cases (a command while busy, a done pulse while idle) the bench checks status, command readback and `be_start` in the cycles straight after the stimulus.

// File: rtl/hacc_pkg.sv
package hacc_pkg;

    localparam int DW = 32;

    // Register byte offsets (software decodes these)
    localparam logic [7:0] OFF_STATUS = 8'h1C;
    localparam logic [7:0] OFF_CFG0   = 8'h20;
    localparam logic [7:0] OFF_CMD    = 8'h30;
    localparam int         NUM_CFG    = 4;

    // Status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 9;
    localparam int ST_ERR  = 23;

    // Command bit positions
    localparam int CMD_BIGEND = 3;
    localparam int CMD_ACCUM  = 8;

    typedef enum logic [1:0] {
        HALG_160  = 2'd0,
        HALG_256  = 2'd1,
        HALG_384  = 2'd2,
        HALG_512  = 2'd3
    } halg_e;

    typedef struct packed {
        logic  valid;
        halg_e algo;
        logic  accum;
        logic  bigend;
    } hcmd_t;

    function automatic hcmd_t decode_cmd(input logic [DW-1:0] w);
        hcmd_t      d;
        logic [3:0] code;
        code     = {w[10], w[6], w[5], w[4]};
        d.accum  = w[CMD_ACCUM];
        d.bigend = w[CMD_BIGEND];
        d.valid  = 1'b1;
        case (code)
            4'b0010: d.algo = HALG_160;
            4'b0101: d.algo = HALG_256;
            4'b1110: d.algo = HALG_384;
            4'b0110: d.algo = HALG_512;
            default: begin
                d.algo  = HALG_160;
                d.valid = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hacc_cfg_regs.sv
module hacc_cfg_regs
    import hacc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NREG   = NUM_CFG
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wen,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  regs_q
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(int'(OFF_CFG0) + 4 * i);
        logic hit;
        assign hit = wen && (addr == MY_OFF);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (hit)
                regs_q[i] <= wdata;
        end
    end

endmodule

// File: rtl/hacc_job_ctrl.sv
module hacc_job_ctrl
    import hacc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              be_done,
    output logic              busy,
    output logic              done_flag,
    output logic              err_flag,
    output logic              start,
    output logic [DW-1:0]     cmd_q,
    output hcmd_t             cmd_dec
);

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STATUS);

    hcmd_t wr_dec;
    logic  cmd_hit, sts_hit, accept, launch, reject, finish;
    logic  done_set, done_clr, err_clr;

    always_comb begin
        wr_dec   = decode_cmd(wdata);
        cmd_hit  = wen && (addr == A_CMD);
        sts_hit  = wen && (addr == A_STS);
        accept   = cmd_hit && !busy;
        launch   = accept && wr_dec.valid;
        reject   = accept && !wr_dec.valid;
        finish   = busy && be_done;
        done_set = finish || reject;
        done_clr = sts_hit && wdata[ST_DONE];
        err_clr  = sts_hit && wdata[ST_ERR];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
            start     <= 1'b0;
            cmd_q     <= '0;
        end else begin
            start <= launch;
            if (accept)
                cmd_q <= wdata;
            if (launch)
                busy <= 1'b1;
            else if (finish)
                busy <= 1'b0;
            if (done_set)
                done_flag <= 1'b1;
            else if (done_clr)
                done_flag <= 1'b0;
            if (reject)
                err_flag <= 1'b1;
            else if (err_clr)
                err_flag <= 1'b0;
        end
    end

    assign cmd_dec = decode_cmd(cmd_q);

endmodule

// File: rtl/hacc_rd_mux.sv
module hacc_rd_mux
    import hacc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NREG   = NUM_CFG
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DW-1:0]           status_w,
    input  logic [NREG-1:0][DW-1:0] cfg,
    input  logic [DW-1:0]           cmd_w,
    output logic [DW-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_STATUS))
            rdata = status_w;
        if (addr == ADDR_W'(OFF_CMD))
            rdata = cmd_w;
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_W'(int'(OFF_CFG0) + 4 * i))
                rdata = cfg[i];
        end
    end

endmodule

// File: rtl/hacc_csr.sv
module hacc_csr
    import hacc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              be_start,
    output logic [DW-1:0]     be_src,
    output logic [DW-1:0]     be_digest,
    output logic [DW-1:0]     be_key,
    output logic [DW-1:0]     be_len,
    output logic [1:0]        be_algo,
    output logic              be_accum,
    output logic              be_bigend,
    input  logic              be_done
);

    logic [NUM_CFG-1:0][DW-1:0] cfg_q;
    logic [DW-1:0]              cmd_q;
    logic [DW-1:0]              status_w;
    hcmd_t                      cmd_dec;
    logic                       busy_w, done_w, err_w;

    hacc_cfg_regs #(.ADDR_W(ADDR_W), .NREG(NUM_CFG)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wen    (bus_wen),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .regs_q (cfg_q)
    );

    hacc_job_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wen       (bus_wen),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .be_done   (be_done),
        .busy      (busy_w),
        .done_flag (done_w),
        .err_flag  (err_w),
        .start     (be_start),
        .cmd_q     (cmd_q),
        .cmd_dec   (cmd_dec)
    );

    always_comb begin
        status_w          = '0;
        status_w[ST_BUSY] = busy_w;
        status_w[ST_DONE] = done_w;
        status_w[ST_ERR]  = err_w;
    end

    hacc_rd_mux #(.ADDR_W(ADDR_W), .NREG(NUM_CFG)) u_rd (
        .addr     (bus_addr),
        .status_w (status_w),
        .cfg      (cfg_q),
        .cmd_w    (cmd_q),
        .rdata    (bus_rdata)
    );

    assign irq       = done_w;
    assign be_src    = cfg_q[0];
    assign be_digest = cfg_q[1];
    assign be_key    = cfg_q[2];
    assign be_len    = cfg_q[3];
    assign be_algo   = cmd_dec.algo;
    assign be_accum  = cmd_dec.accum;
    assign be_bigend = cmd_dec.bigend;

endmodule

// File: rtl/hacc_csr_chk.sv
module hacc_csr_chk
    import hacc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic [DW-1:0]     bus_wdata,
    input logic              be_start,
    input logic              be_done,
    input logic              busy,
    input logic              done_flag,
    input logic              err_flag,
    input logic              irq
);

    logic sts_wr;
    assign sts_wr = bus_wen && (bus_addr == ADDR_W'(OFF_STATUS));

    // R3: start is a single-cycle pulse and coincides with busy
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
        be_start |=> !be_start);
    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        be_start |-> busy);

    // R4: completion clears busy and raises done on one edge
    a_r4_done_ends_job: assert property (@(posedge clk) disable iff (rst)
        (busy && be_done) |=> (!busy && done_flag && irq));

    // R5: no launch can follow a busy cycle
    a_r5_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> !be_start);

    // R6: write-one clear of done when no completion competes
    a_r6_w1c_done: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && bus_wdata[ST_DONE] && !busy) |=> !done_flag);

    // R7: a rejected command raises error with done and never starts
    a_r7_reject: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> (done_flag && !be_start && !busy));

    // R8: error clear by write-one
    a_r8_w1c_err: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && bus_wdata[ST_ERR]) |=> !err_flag);

    // R9: with no bus write and no job, status does not move
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !bus_wen) |=> ($stable(done_flag) && $stable(err_flag) && !busy));

endmodule

bind hacc_csr hacc_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .be_start  (be_start),
    .be_done   (be_done),
    .busy      (busy_w),
    .done_flag (done_w),
    .err_flag  (err_w),
    .irq       (irq)
);

// File: tb/tb_hacc_csr.sv
`timescale 1ns/1ps
module tb_hacc_csr;

    localparam int  CLK_NS = 20;
    localparam int  LAT    = 6;
    localparam logic [7:0] A_STS = 8'h1C, A_SRC = 8'h20, A_DIG = 8'h24,
                           A_KEY = 8'h28, A_LEN = 8'h2C, A_CMD = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, be_start, be_accum, be_bigend, be_done;
    logic [31:0] be_src, be_digest, be_key, be_len;
    logic [1:0]  be_algo;

    logic        stub_en = 1'b1;
    logic        stub_done = 1'b0;
    logic        man_done = 1'b0;
    int          stub_cnt = 0;
    int          checks = 0;
    int          errors = 0;

    assign be_done = stub_done | man_done;

    always #(CLK_NS/2) clk = ~clk;

    hacc_csr dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .be_start(be_start), .be_src(be_src), .be_digest(be_digest),
        .be_key(be_key), .be_len(be_len), .be_algo(be_algo),
        .be_accum(be_accum), .be_bigend(be_bigend), .be_done(be_done)
    );

    // Fixed-latency back-end stub
    always @(posedge clk) begin
        if (rst) begin
            stub_cnt  <= 0;
            stub_done <= 1'b0;
        end else if (stub_en && be_start) begin
            stub_cnt  <= LAT;
            stub_done <= 1'b0;
        end else if (stub_cnt > 0) begin
            stub_cnt  <= stub_cnt - 1;
            stub_done <= (stub_cnt == 1);
        end else begin
            stub_done <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); #1;
            if (be_done) break;
        end
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STS, v); chk("R1 status", v, 0);
        rd(A_SRC, v); chk("R1 src", v, 0);
        rd(A_DIG, v); chk("R1 digest", v, 0);
        rd(A_KEY, v); chk("R1 key", v, 0);
        rd(A_LEN, v); chk("R1 len", v, 0);
        rd(A_CMD, v); chk("R1 cmd", v, 0);
        chk("R1 start", be_start, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr(A_SRC, 32'h8000_1000);
        wr(A_DIG, 32'h8000_2040);
        wr(A_KEY, 32'hA5A5_5A5A);
        wr(A_LEN, 32'd128);
        rd(A_SRC, v); chk("R2 src rb", v, 32'h8000_1000);
        rd(A_DIG, v); chk("R2 digest rb", v, 32'h8000_2040);
        rd(A_KEY, v); chk("R2 key rb", v, 32'hA5A5_5A5A);
        rd(A_LEN, v); chk("R2 len rb", v, 32'd128);
        chk("R2 be_src", be_src, 32'h8000_1000);
        chk("R2 be_digest", be_digest, 32'h8000_2040);
        chk("R2 be_key", be_key, 32'hA5A5_5A5A);
        chk("R2 be_len", be_len, 32'd128);
        wr(A_LEN, 32'hFFFF_FFFF);
        rd(A_LEN, v); chk("R2 len overwrite", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_job(input logic [31:0] cmd, input logic [1:0] ealg);
        logic [31:0] v;
        wr(A_STS, 32'h0000_0200);
        wr(A_CMD, cmd);
        chk("R3 start pulse", be_start, 1);
        rd(A_STS, v); chk("R3 busy set", v, 32'h1);
        chk("R3 algo", be_algo, ealg);
        chk("R3 accum", be_accum, cmd[8]);
        chk("R3 bigend", be_bigend, cmd[3]);
        @(negedge clk); #1;
        chk("R3 start drops", be_start, 0);
        wait_done();
        rd(A_STS, v); chk("R4 done, busy clear", v, 32'h0000_0200);
        chk("R4 irq", irq, 1);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(A_STS, 32'h0000_0200);
        wr(A_CMD, 32'h0000_0050);
        wr(A_CMD, 32'h0000_0128);
        chk("R5 no start", be_start, 0);
        rd(A_CMD, v); chk("R5 cmd kept", v, 32'h0000_0050);
        chk("R5 algo kept", be_algo, 2'd1);
        chk("R5 accum kept", be_accum, 0);
        @(negedge clk); #1;
        chk("R5 no start later", be_start, 0);
        wait_done();
        rd(A_STS, v); chk("R5 job ends", v, 32'h0000_0200);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_STS, 32'h0000_0001);
        rd(A_STS, v); chk("R6 zero write keeps done", v, 32'h0000_0200);
        wr(A_STS, 32'h0000_0200);
        rd(A_STS, v); chk("R6 w1c clears", v, 0);
        chk("R6 irq low", irq, 0);
        // collision: completion and clear on one edge
        stub_en = 1'b0;
        wr(A_CMD, 32'h0000_0060);
        @(negedge clk);
        man_done = 1'b1;
        bus_wen = 1'b1; bus_addr = A_STS; bus_wdata = 32'h0000_0200;
        @(negedge clk);
        man_done = 1'b0; bus_wen = 1'b0;
        #1;
        rd(A_STS, v); chk("R6 set wins", v, 32'h0000_0200);
        stub_en = 1'b1;
        wr(A_STS, 32'h0000_0200);
    endtask

    task automatic t_invalid();
        logic [31:0] v;
        wr(A_CMD, 32'h0000_0070);
        chk("R7 no start", be_start, 0);
        rd(A_STS, v); chk("R7 done+err", v, 32'h0080_0200);
        rd(A_CMD, v); chk("R7 cmd rb", v, 32'h0000_0070);
        @(negedge clk); #1;
        chk("R7 still no start", be_start, 0);
        wr(A_STS, 32'h0080_0000);
        rd(A_STS, v); chk("R8 err cleared, done kept", v, 32'h0000_0200);
        wr(A_STS, 32'h0000_0200);
        wr(A_CMD, 32'h0000_0000);
        rd(A_STS, v); chk("R7 zero code rejected", v, 32'h0080_0200);
        wr(A_STS, 32'h0080_0200);
        rd(A_STS, v); chk("R8 both cleared", v, 0);
    endtask

    task automatic t_idle_done();
        logic [31:0] v;
        @(negedge clk);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        #1;
        rd(A_STS, v); chk("R9 idle done ignored", v, 0);
        chk("R9 irq low", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_cfg();
        t_job(32'h0000_0128, 2'd0);
        t_job(32'h0000_0050, 2'd1);
        t_job(32'h0000_0468, 2'd2);
        t_job(32'h0000_0160, 2'd3);
        t_busy_ignore();
        t_w1c();
        t_invalid();
        t_idle_done();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule